// File: doc/BRIEF.md
# Configurable Port Routing Box

A mesh tile in a coarse-grained reconfigurable array has a routing box on each of its four sides. The box covered here drives one outgoing port word of that side. Its candidate sources are the two result words of the tile's processing core and every incoming port word that arrives on the other three sides. The side's own incoming ports are not candidates, so a word cannot be sent straight back where it came from. A port word is 17 bits wide: a 16-bit data field plus one execute-enable (valid) bit.

The configuration word is loaded before the array runs and stays fixed while it executes. It holds two things. The first is a source index. The second is a pipeline bit, which chooses one of two paths for the selected word. On the first path the word leaves the box combinationally. On the second path the word passes through one register stage, so the route also acts as a one-cycle delay element in a pipelined interconnect. A source index beyond the last source drives an all-zero word, and an all-zero word carries no valid token.

Top module: `port_route_box`

## Requirements
- R1: A port word carries data in bits 15:0 and execute-enable in bit 16. The box carries both fields unchanged on either path, and neither field affects the other.
- R2: Source index 0 selects core result A and source index 1 selects core result B.
- R3: Source indices from 2 upward select incoming port words from the other three sides. The sides go in ascending side number, skipping the box's own side (parameter SIDE). Within a side the ports go in ascending order. Incoming port p of side s sits at bits (s*NP+p)*17 of `port_in`.
- R4: A source index of 3*NP+2 or more drives an all-zero word, so execute-enable is 0.
- R5: The configuration word holds the source index in bits SEL_W-1:0, with SEL_W = ceil(log2(3*NP+2)) (4 by default). When bit SEL_W is 0, `port_out` equals the selected word in the same cycle.
- R6: When bit SEL_W is 1, `port_out` equals the word that was selected at the previous rising clock edge. Data and execute-enable are delayed together.
- R7: While `rst_n` is low, the register stage is cleared. With bit SEL_W set, `port_out` is all zero during reset and no valid token leaves the box.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | SEL_W+1 (5) | Source index in the low bits, pipeline bit at the top |
| core_a | input | 17 | Processing core result A |
| core_b | input | 17 | Processing core result B |
| port_in | input | 4*NP*17 (204) | Incoming port words of all four sides, packed |
| port_out | output | 17 | Outgoing port word |

## Verification
On every cycle the assertions check the following: the pass-through path equals the route multiplexer output, the delay path equals that output one cycle later, an out-of-range index yields a zero word, index 0 reaches core A, and the delay path is clear during reset. The bench's scenarios are needed to show the full source ordering, including that the box's own side is skipped. They also show that the two fields stay independent under chosen bit patterns and that the first word after reset release is correct. For these checks the bench compares the output with a behavioural model on every cycle.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic {
    PRB_PASS  = 1'b0,
    PRB_DELAY = 1'b1
  } prb_mode_e;
endpackage

// File: rtl/prb_src_gather.sv
module prb_src_gather #(
  parameter int NP     = 3,
  parameter int SIDE   = 0,
  parameter int WORD_W = 17,
  localparam int NSRC  = 3 * NP + 2
) (
  input  logic [WORD_W-1:0]        core_a,
  input  logic [WORD_W-1:0]        core_b,
  input  logic [4*NP*WORD_W-1:0]   port_in,
  output logic [NSRC*WORD_W-1:0]   src_flat
);
  assign src_flat[0 +: WORD_W]      = core_a;
  assign src_flat[WORD_W +: WORD_W] = core_b;

  for (genvar s = 0; s < 4; s++) begin : g_side
    if (s != SIDE) begin : g_used
      localparam int SLOT_SIDE = (s < SIDE) ? s : s - 1;
      for (genvar p = 0; p < NP; p++) begin : g_port
        localparam int SLOT = 2 + SLOT_SIDE * NP + p;
        assign src_flat[SLOT*WORD_W +: WORD_W] = port_in[(s*NP+p)*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/prb_route_mux.sv
module prb_route_mux #(
  parameter int NSRC   = 11,
  parameter int SEL_W  = 4,
  parameter int WORD_W = 17
) (
  input  logic [SEL_W-1:0]       sel,
  input  logic [NSRC*WORD_W-1:0] src_flat,
  output logic [WORD_W-1:0]      sel_word
);
  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (int'(sel) == i) sel_word = src_flat[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/prb_delay_stage.sv
module prb_delay_stage #(
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/port_route_box.sv
module port_route_box
  import prb_pkg::*;
#(
  parameter int NP     = 3,
  parameter int SIDE   = 0,
  parameter int DATA_W = 16,
  localparam int WORD_W = DATA_W + 1,
  localparam int NSRC   = 3 * NP + 2,
  localparam int SEL_W  = $clog2(NSRC),
  localparam int CFG_W  = SEL_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CFG_W-1:0]         cfg,
  input  logic [WORD_W-1:0]        core_a,
  input  logic [WORD_W-1:0]        core_b,
  input  logic [4*NP*WORD_W-1:0]   port_in,
  output logic [WORD_W-1:0]        port_out
);
  logic [NSRC*WORD_W-1:0] src_flat;
  logic [WORD_W-1:0]      sel_word;
  logic [WORD_W-1:0]      dly_word;
  prb_mode_e              mode;

  assign mode = prb_mode_e'(cfg[SEL_W]);

  prb_src_gather #(.NP(NP), .SIDE(SIDE), .WORD_W(WORD_W)) u_gather (
    .core_a   (core_a),
    .core_b   (core_b),
    .port_in  (port_in),
    .src_flat (src_flat)
  );

  prb_route_mux #(.NSRC(NSRC), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_mux (
    .sel      (cfg[SEL_W-1:0]),
    .src_flat (src_flat),
    .sel_word (sel_word)
  );

  prb_delay_stage #(.WORD_W(WORD_W)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mode == PRB_DELAY),
    .d     (sel_word),
    .q     (dly_word)
  );

  assign port_out = (mode == PRB_DELAY) ? dly_word : sel_word;
endmodule

// File: rtl/prb_chk.sv
module prb_chk #(
  parameter int WORD_W = 17,
  parameter int SEL_W  = 4,
  parameter int NSRC   = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W:0]    cfg,
  input logic [WORD_W-1:0] core_a,
  input logic [WORD_W-1:0] sel_word,
  input logic [WORD_W-1:0] port_out
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R5
  pass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[SEL_W] |-> port_out == sel_word);

  // R6
  delay_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfg[SEL_W] && $past(cfg[SEL_W])) |-> port_out == $past(sel_word));

  // R4
  out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[SEL_W] && int'(cfg[SEL_W-1:0]) >= NSRC) |-> port_out == '0);

  // R2
  core_a_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[SEL_W] && cfg[SEL_W-1:0] == '0) |-> port_out == core_a);

  // R7
  always @(posedge clk) begin
    if (!rst_n && cfg[SEL_W]) begin
      reset_clear_chk: assert (port_out == '0);
    end
  end
endmodule

bind port_route_box prb_chk #(.WORD_W(WORD_W), .SEL_W(SEL_W), .NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg      (cfg),
  .core_a   (core_a),
  .sel_word (sel_word),
  .port_out (port_out)
);

// File: tb/test_port_route_box.sv
`timescale 1ns/1ps
module test_port_route_box;
  localparam int NP   = 3;
  localparam int SIDE = 2;
  localparam int W    = 17;
  localparam int NSRC = 3 * NP + 2;
  localparam int SW   = 4;
  localparam int PW   = 4 * NP * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [SW:0]   cfg;
  logic [W-1:0]  ca, cb;
  logic [PW-1:0] pin;
  logic [W-1:0]  pout;
  logic [W-1:0]  model_q;
  logic [W-1:0]  pat;
  string         req;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  port_route_box #(.NP(NP), .SIDE(SIDE), .DATA_W(16)) i_port_route_box (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .core_a(ca), .core_b(cb),
    .port_in(pin), .port_out(pout)
  );

  function automatic logic [W-1:0] ref_sel(input logic [SW:0] c);
    int idx = int'(c[SW-1:0]);
    int k = 2;
    if (idx == 0) return ca;
    if (idx == 1) return cb;
    for (int s = 0; s < 4; s++) begin
      if (s == SIDE) continue;
      for (int p = 0; p < NP; p++) begin
        if (idx == k) return pin[(s*NP+p)*W +: W];
        k++;
      end
    end
    return '0;
  endfunction

  task automatic check();
    logic [W-1:0] exp;
    if (cfg[SW]) exp = rst_n ? model_q : '0;
    else         exp = ref_sel(cfg);
    n_run++;
    if (pout !== exp) begin
      n_fail++;
      $display("FAIL %s cfg=%h actual=%h expected=%h", req, cfg, pout, exp);
    end
  endtask

  task automatic rnd_inputs();
    ca = W'($urandom);
    cb = W'($urandom);
    for (int i = 0; i < 4*NP; i++) pin[i*W +: W] = W'($urandom);
  endtask

  // mode 0: keep inputs, 1: random, 2: pattern on every source
  task automatic step(input logic [SW:0] c, input logic rn, input int mode);
    @(negedge clk);
    check();
    cfg   = c;
    rst_n = rn;
    if (mode == 1) rnd_inputs();
    if (mode == 2) begin
      ca = pat; cb = pat;
      for (int i = 0; i < 4*NP; i++) pin[i*W +: W] = pat;
    end
    if (!rn)        model_q = '0;
    else if (c[SW]) model_q = ref_sel(c);
  endtask

  initial begin
    rst_n = 1'b0; cfg = 5'b10000; model_q = '0; pat = '0;
    rnd_inputs();
    // R7: delay path held at zero during reset, even with live inputs
    req = "R7";
    for (int i = 0; i < 4; i++) step(5'b10000 | 5'(i), 1'b0, 1);
    step(5'b10011, 1'b1, 1);
    step(5'b10011, 1'b1, 1);
    // R2: core results
    req = "R2";
    for (int i = 0; i < 8; i++) step(5'b00000, 1'b1, 1);
    for (int i = 0; i < 8; i++) step(5'b00001, 1'b1, 1);
    // R3: port sources, own side skipped
    req = "R3";
    for (int s = 2; s < NSRC; s++)
      for (int i = 0; i < 4; i++) step(5'(s), 1'b1, 1);
    // R4: out-of-range indices
    req = "R4";
    for (int s = NSRC; s < 16; s++)
      for (int i = 0; i < 3; i++) step(5'(s), 1'b1, 1);
    // R5: pass path, same-cycle response to changing inputs
    req = "R5";
    for (int i = 0; i < 30; i++) step(5'($urandom_range(0, NSRC-1)), 1'b1, 1);
    // R6: delay path across every source
    req = "R6";
    for (int s = 0; s < NSRC; s++)
      for (int i = 0; i < 5; i++) step(5'b10000 | 5'(s), 1'b1, 1);
    // R1: fields independent on both paths
    req = "R1";
    pat = 17'h10000; step(5'b00110, 1'b1, 2); step(5'b10110, 1'b1, 2);
    pat = 17'h0FFFF; step(5'b00110, 1'b1, 2); step(5'b10110, 1'b1, 2);
    pat = 17'h1A5C3; step(5'b00000, 1'b1, 2); step(5'b10000, 1'b1, 2);
    step(5'b10000, 1'b1, 0);
    // R7: reset asserted mid-run clears delay path
    req = "R7";
    step(5'b10000, 1'b0, 1);
    step(5'b10000, 1'b0, 1);
    step(5'b10000, 1'b1, 1);
    @(negedge clk);
    check();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule